// File: doc/BRIEF.md
# Mixed-Width Pointer-Indirect Store Sequencer

This block carries out one register-to-memory store through a pointer on a processor with two addressing regimes: a native mode with 24-bit registers and addresses, and a compatibility mode with 16-bit registers and an 8-bit base byte that supplies the top of every address. An instruction may carry a suffix that overrides the global mode for that one instruction. The suffix has two parts. The data-width part chooses the register width and how the address is formed. The immediate-length part only matters for instructions that carry an immediate operand, and the pointer store has none.

When `start` is seen while the block is idle, it fixes the effective width, the start address and the source value. It then writes the operand one byte per cycle on a simple write port, least significant byte first. A `done` pulse follows the last byte. In 16-bit addressing only the low 16 bits of the address step, and the base byte stays constant.

Top module: `mixw_store`

## Requirements
- R1: With `modeNative`=1 and `sfxValid`=0, three bytes are written to `ptrReg`, `ptrReg`+1 and `ptrReg`+2, with modulo-2^24 stepping, and `opWide` reads 1 while writing.
- R2: With `modeNative`=0 and `sfxValid`=0, two bytes are written to {`baseReg`, `ptrReg[15:0]`} and the next offset, and `opWide` reads 0.
- R3: With `sfxValid`=1 and `sfxLong`=0 (short data suffix), in either mode, only `srcReg[15:0]` is stored (two bytes) at {`baseReg`, `ptrReg[15:0]`}. A short suffix in compatibility mode therefore matches the unsuffixed store.
- R4: With `sfxValid`=1 and `sfxLong`=1 (long data suffix), in either mode, three bytes are stored at the full `ptrReg` and `baseReg` is not used. A long suffix in native mode therefore matches the unsuffixed store.
- R5: `sfxImmLong` has no effect on any address, data, width or timing seen at the ports.
- R6: Byte k of the sequence (k from 0) carries `srcReg[8k+7:8k]`, so bytes go out least significant first.
- R7: In 16-bit addressing the offset wraps from 0xFFFF to 0x0000 and the upper address byte keeps the `baseReg` value for the whole sequence.
- R8: If `start` is high at a rising edge while idle, `wrEn` is high for the next 2 or 3 cycles, one per byte. `done` is high for exactly the one cycle after the last write. `busy` is high from the first write cycle through the `done` cycle.
- R9: `start` is ignored while `busy` is high. No extra writes occur and no new sequence begins.
- R10: Width, address and data are captured at the accepted `start`. Changes to the mode, suffix or register inputs during the sequence do not change the transfer.
- R11: During and after reset, `busy`, `wrEn` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to launch a store |
| modeNative | input | 1 | Global mode: 1 = 24-bit native, 0 = 16-bit compatibility |
| sfxValid | input | 1 | The instruction carries a width suffix |
| sfxLong | input | 1 | Data-width part of the suffix: 1 = long, 0 = short |
| sfxImmLong | input | 1 | Immediate-length part of the suffix (no effect here) |
| baseReg | input | 8 | Memory base byte for 16-bit addressing |
| ptrReg | input | 24 | Pointer register |
| srcReg | input | 24 | Source register pair |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse after the last byte |
| wrEn | output | 1 | Write strobe, one byte per cycle |
| wrAddr | output | 24 | Byte write address |
| wrData | output | 8 | Byte write data |
| opWide | output | 1 | Captured width: 1 = 24-bit, 0 = 16-bit |

## Verification
The assertions assume the block is the only driver of its write port and that reset is applied before the first `start`. They make no assumption about the stability of any input during a sequence. The stimulus deliberately holds `start` high and scrambles the mode, suffix and register inputs on every cycle of many random sequences, so the ignore and latch properties are tested against the worst input behaviour. Directed cases cover every mode and suffix combination, both settings of the immediate-length bit, and offsets that cross the 16-bit and 24-bit wrap points.

// File: rtl/mixw_pkg.sv
package mixw_pkg;
  // Sequencer states
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_FIN   = 2'd2
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture width, address and data
    logic step;   // advance to the next byte
  } dpCmd_t;
endpackage

// File: rtl/mixw_ctrl.sv
module mixw_ctrl
  import mixw_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   lastByte,
  output dpCmd_t cmd,
  output logic   busy,
  output logic   wrEn,
  output logic   done
);
  seqState_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    cmd      = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          cmd.load = 1'b1;
          stateNxt = ST_WRITE;
        end
      end
      ST_WRITE: begin
        cmd.step = 1'b1;
        if (lastByte) stateNxt = ST_FIN;
      end
      ST_FIN:  stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign wrEn = (state == ST_WRITE);
  assign done = (state == ST_FIN);
endmodule

// File: rtl/mixw_dp.sv
module mixw_dp
  import mixw_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int OFS_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic              modeNative,
  input  logic              sfxValid,
  input  logic              sfxLong,
  input  logic [BYTE_W-1:0] baseReg,
  input  logic [ADDR_W-1:0] ptrReg,
  input  logic [ADDR_W-1:0] srcReg,
  output logic              lastByte,
  output logic              opWide,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [BYTE_W-1:0] wrData
);
  localparam int NB_WIDE  = ADDR_W / BYTE_W;
  localparam int NB_SHORT = OFS_W / BYTE_W;
  localparam int IDX_W    = $clog2(NB_WIDE);
  localparam int HI_W     = ADDR_W - OFS_W;

  logic              wideSel;
  logic [ADDR_W-1:0] startAddr;
  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] dataQ;
  logic [IDX_W-1:0]  idxQ;
  logic              wideQ;
  logic [ADDR_W-1:0] addrInc;
  logic [BYTE_W-1:0] byteLane [NB_WIDE];

  // The data-width part of the suffix overrides the mode. The
  // immediate-length part is deliberately not an input here.
  assign wideSel = sfxValid ? sfxLong : modeNative;

  // The base byte is placed on top only in 16-bit addressing.
  always_comb begin
    if (wideSel) startAddr = ptrReg;
    else         startAddr = {baseReg, ptrReg[OFS_W-1:0]};
  end

  // Native mode steps the whole address. Short mode steps only the offset.
  always_comb begin
    if (wideQ) addrInc = addrQ + ADDR_W'(1);
    else       addrInc = {addrQ[ADDR_W-1:OFS_W], addrQ[OFS_W-1:0] + OFS_W'(1)};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      idxQ  <= '0;
      wideQ <= 1'b0;
    end else if (cmd.load) begin
      addrQ <= startAddr;
      dataQ <= wideSel ? srcReg : {{HI_W{1'b0}}, srcReg[OFS_W-1:0]};
      idxQ  <= '0;
      wideQ <= wideSel;
    end else if (cmd.step) begin
      addrQ <= addrInc;
      idxQ  <= idxQ + IDX_W'(1);
    end
  end

  // Split the captured operand into byte lanes.
  for (genvar g = 0; g < NB_WIDE; g++) begin : g_lane
    assign byteLane[g] = dataQ[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    wrData = '0;
    for (int k = 0; k < NB_WIDE; k++)
      if (idxQ == IDX_W'(k)) wrData = byteLane[k];
  end

  assign lastByte = wideQ ? (idxQ == IDX_W'(NB_WIDE - 1))
                          : (idxQ == IDX_W'(NB_SHORT - 1));
  assign opWide   = wideQ;
  assign wrAddr   = addrQ;
endmodule

// File: rtl/mixw_store.sv
module mixw_store
  import mixw_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int OFS_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              modeNative,
  input  logic              sfxValid,
  input  logic              sfxLong,
  input  logic              sfxImmLong,
  input  logic [BYTE_W-1:0] baseReg,
  input  logic [ADDR_W-1:0] ptrReg,
  input  logic [ADDR_W-1:0] srcReg,
  output logic              busy,
  output logic              done,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [BYTE_W-1:0] wrData,
  output logic              opWide
);
  dpCmd_t cmd;
  logic   lastByte;
  logic   immUnused;

  // No immediate operand, so the length part of the suffix has no effect.
  assign immUnused = sfxImmLong;

  mixw_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .lastByte (lastByte),
    .cmd      (cmd),
    .busy     (busy),
    .wrEn     (wrEn),
    .done     (done)
  );

  mixw_dp #(
    .ADDR_W (ADDR_W),
    .OFS_W  (OFS_W),
    .BYTE_W (BYTE_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .modeNative (modeNative),
    .sfxValid   (sfxValid),
    .sfxLong    (sfxLong),
    .baseReg    (baseReg),
    .ptrReg     (ptrReg),
    .srcReg     (srcReg),
    .lastByte   (lastByte),
    .opWide     (opWide),
    .wrAddr     (wrAddr),
    .wrData     (wrData)
  );
endmodule

// File: rtl/mixw_store_chk.sv
module mixw_store_chk #(
  parameter int ADDR_W = 24,
  parameter int OFS_W  = 16,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              opWide
);
  localparam int NB_WIDE  = ADDR_W / BYTE_W;
  localparam int NB_SHORT = OFS_W / BYTE_W;

  logic [3:0] wrCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     wrCnt <= '0;
    else if (done) wrCnt <= '0;
    else if (wrEn) wrCnt <= wrCnt + 4'd1;
  end

  AST_WR_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> busy); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8

  AST_DONE_AFTER_WR: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(wrEn)); // R8

  AST_BYTE_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (wrCnt == (opWide ? 4'(NB_WIDE) : 4'(NB_SHORT)))); // R3

  AST_BASE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !opWide && $past(wrEn)) |->
      (wrAddr[ADDR_W-1:OFS_W] == $past(wrAddr[ADDR_W-1:OFS_W]))); // R7

  AST_OFS_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !opWide && $past(wrEn)) |->
      (wrAddr[OFS_W-1:0] == OFS_W'($past(wrAddr[OFS_W-1:0]) + 1'b1))); // R7

  AST_WIDE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && opWide && $past(wrEn)) |->
      (wrAddr == ADDR_W'($past(wrAddr) + 1'b1))); // R1

  AST_WIDTH_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(opWide)); // R10

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !done) |=> busy); // R9
endmodule

bind mixw_store mixw_store_chk #(
  .ADDR_W (ADDR_W),
  .OFS_W  (OFS_W),
  .BYTE_W (BYTE_W)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .wrEn   (wrEn),
  .wrAddr (wrAddr),
  .opWide (opWide)
);

// File: tb/mixw_store_test.sv
module mixw_store_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        modeNative = 1'b0;
  logic        sfxValid = 1'b0;
  logic        sfxLong = 1'b0;
  logic        sfxImmLong = 1'b0;
  logic [7:0]  baseReg = '0;
  logic [23:0] ptrReg = '0;
  logic [23:0] srcReg = '0;
  logic        busy, done, wrEn, opWide;
  logic [23:0] wrAddr;
  logic [7:0]  wrData;

  int nChk = 0;
  int nErr = 0;

  always #5 clk = ~clk;

  mixw_store uut (
    .clk(clk), .rstN(rstN), .start(start), .modeNative(modeNative),
    .sfxValid(sfxValid), .sfxLong(sfxLong), .sfxImmLong(sfxImmLong),
    .baseReg(baseReg), .ptrReg(ptrReg), .srcReg(srcReg),
    .busy(busy), .done(done), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .opWide(opWide)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [23:0] expAddr(input logic wide, input logic [7:0] b,
                                          input logic [23:0] p, input int k);
    logic [15:0] o;
    o = p[15:0] + 16'(k);
    return wide ? 24'(p + 24'(k)) : {b, o};
  endfunction

  function automatic logic [7:0] expByte(input logic [23:0] s, input int k);
    return s[k*8 +: 8];
  endfunction

  task automatic scramble();
    modeNative = 1'($urandom); sfxValid = 1'($urandom); sfxLong = 1'($urandom);
    sfxImmLong = 1'($urandom); baseReg = 8'($urandom);
    ptrReg = 24'($urandom); srcReg = 24'($urandom);
  endtask

  // One store: tag names the address rule, perturb exercises R9 and R10
  task automatic runSeq(input string tag, input logic m, input logic sv,
                        input logic sl, input logic si, input logic [7:0] b,
                        input logic [23:0] p, input logic [23:0] s, input bit perturb);
    logic wide;
    int n;
    wide = sv ? sl : m;
    n = wide ? 3 : 2;
    @(negedge clk);
    modeNative = m; sfxValid = sv; sfxLong = sl; sfxImmLong = si;
    baseReg = b; ptrReg = p; srcReg = s; start = 1'b1;
    @(negedge clk);
    if (!perturb) start = 1'b0;
    for (int k = 0; k < n; k++) begin
      chk({tag, " wrEn"}, 32'(wrEn), 32'd1);
      chk({tag, " addr"}, 32'(wrAddr), 32'(expAddr(wide, b, p, k)));
      chk("R6 data", 32'(wrData), 32'(expByte(s, k)));
      chk({tag, " width"}, 32'(opWide), 32'(wide));
      chk("R8 busy", 32'(busy), 32'd1);
      if (perturb) scramble();
      @(negedge clk);
    end
    chk("R8 done pulse", 32'(done), 32'd1);
    chk(perturb ? "R9 no extra write" : "R8 write ends", 32'(wrEn), 32'd0);
    start = 1'b0;
    @(negedge clk);
    chk("R8 done drop", 32'(done), 32'd0);
    chk("R8 idle", 32'(busy), 32'd0);
  endtask

  initial begin
    #2_000_000;
    nErr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

  initial begin
    void'($urandom(32'h1f2e3d4c));
    repeat (3) @(negedge clk);
    chk("R11 busy", 32'(busy), 32'd0);
    chk("R11 wrEn", 32'(wrEn), 32'd0);
    chk("R11 done", 32'(done), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11 idle after", 32'(busy), 32'd0);

    runSeq("R1",  1, 0, 0, 0, 8'hA5, 24'h123456, 24'hC0FFEE, 0);
    runSeq("R2",  0, 0, 1, 0, 8'h5A, 24'h123456, 24'hC0FFEE, 0);
    runSeq("R3",  1, 1, 0, 0, 8'h77, 24'hABCDEF, 24'h112233, 0);
    runSeq("R3",  0, 1, 0, 1, 8'h77, 24'hABCDEF, 24'h112233, 0);
    runSeq("R4",  0, 1, 1, 0, 8'h99, 24'h00FF10, 24'h445566, 0);
    runSeq("R4",  1, 1, 1, 1, 8'h99, 24'h00FF10, 24'h445566, 0);
    runSeq("R5",  1, 1, 0, 1, 8'h33, 24'h0FA0B0, 24'hDEAD01, 0);
    runSeq("R5",  0, 0, 0, 1, 8'h33, 24'h0FA0B0, 24'hDEAD01, 0);
    runSeq("R7",  0, 0, 0, 0, 8'h4C, 24'h12FFFF, 24'hBEEF42, 0);
    runSeq("R7",  1, 1, 0, 0, 8'hE1, 24'h00FFFF, 24'h0055AA, 1);
    runSeq("R1",  1, 0, 0, 0, 8'h00, 24'hFFFFFE, 24'h010203, 0);
    runSeq("R10", 1, 0, 0, 0, 8'h12, 24'h200000, 24'h987654, 1);
    runSeq("R10", 0, 0, 0, 0, 8'h12, 24'h20FFFE, 24'h987654, 1);

    for (int r = 0; r < 300; r++) begin
      logic m, sv, sl, si;
      m = 1'($urandom); sv = 1'($urandom); sl = 1'($urandom); si = 1'($urandom);
      runSeq(sv ? (sl ? "R4" : "R3") : (m ? "R1" : "R2"), m, sv, sl, si,
             8'($urandom), 24'($urandom), 24'($urandom), 1'($urandom));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end
endmodule